// File: doc/BRIEF.md
# Branch Confidence Fork Controller

This block sits next to a branch predictor in a multipath fetch unit. For every conditional branch looked up in fetch, it estimates whether the predictor's guess is trustworthy. It asks for a new execution path (a fork) only when trust is low and a spare path context exists. The estimate comes from a table of per-branch confidence entries indexed by the word address of the branch. The table is trained when branches commit, using the resolved outcome: the prediction was either correct or mispredicted.

Three ways of keeping confidence are available. The first is a history of the last eight outcomes, judged by how many were correct. The second is a signed up/down counter. The third is a counter that climbs on correct predictions and drops to zero on any miss. Three ways of turning an entry into a decision are also available. A fixed limit can be used. The limit can instead be lowered as spare contexts run out, so that scarce contexts go only to the least trusted branches. Finally, the table can be bypassed and a per-branch static category compared with the spare-context count.

A lookup gives its result one cycle later. A commit update becomes visible to lookups from the next cycle on. The counting mode may only change while reset is asserted. The decision mode may change with every lookup.

Top module: `conf_fork_ctrl`

## Requirements
- R1: A lookup presented with `lk_valid_i` high in cycle t gives `res_valid_o` high in cycle t+1 and in no other cycle; `res_high_o` and `res_fork_o` are low whenever `res_valid_o` is low.
- R2: While `rst` is high and in the cycle after it, all outputs are low. Every table entry reads as zero after reset, so a first lookup in fixed decision mode is low confidence.
- R3: Counting mode 0 (ones-count, also used for code 3): an entry is an 8-bit outcome history. A commit shifts in 1 for correct and 0 for mispredicted. The branch is high confidence when more than 6 of the 8 bits are 1. The entry is selected by word-address bits [12:2], so addresses differing only in bit 13 share an entry.
- R4: Counting mode 1 (saturating): an entry is a signed 4-bit counter selected by address bits [13:2]. It adds 1 on a correct commit and subtracts 1 on a misprediction, holding at +7 and -8. It is high confidence above 4.
- R5: Counting mode 2 (resetting): an entry is an unsigned 4-bit counter selected by address bits [13:2]. It adds 1 on a correct commit, holding at 15, and clears to 0 on a misprediction. It is high confidence above 11.
- R6: `res_fork_o` is high only when the result is low confidence and the spare-context count sampled with the lookup is at least 1; a fork result never has `res_high_o` high.
- R7: Decision mode 1 (resource-aware) lowers the limit by (FREE_MAX minus spare contexts), so the entry is high confidence when its score exceeds base limit (6, 4 or 11) minus that amount. Decision modes 0 and 3 use the base limit.
- R8: Decision mode 2 (category) ignores the table: the result forks exactly when the 2-bit category is less than the spare-context count, and is reported high confidence otherwise.
- R9: A lookup and a commit to the same entry in the same cycle return the entry as it was before that commit. A commit in cycle t is seen by a lookup in cycle t+1.
- R10: For 2^IDX_W cycles after reset is released the table is being cleared. Commits in that window are discarded, and lookups in it read the entry as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_mode_i | input | 2 | Counting mode: 0 ones-count, 1 saturating, 2 resetting; changed only in reset |
| thr_mode_i | input | 2 | Decision mode for this lookup: 0 fixed, 1 resource-aware, 2 category |
| free_ctx_i | input | CTX_W | Spare path contexts at lookup time |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W-2 | Word address of the looked-up branch (bits PC_W-1:2) |
| lk_cat_i | input | CAT_W | Static category of the looked-up branch |
| up_valid_i | input | 1 | Commit update request |
| up_pc_i | input | PC_W-2 | Word address of the committing branch |
| up_correct_i | input | 1 | 1 when the committed prediction was correct |
| res_valid_o | output | 1 | Result valid, one cycle after the lookup |
| res_high_o | output | 1 | Result is high confidence |
| res_fork_o | output | 1 | Fork a new path |

## Verification
On every cycle, the assertions check the lookup-to-result timing and that no fork is ever issued without a spare context. They also check that a fork and a high-confidence result exclude each other, and that category mode forks exactly when the category is below the spare count. Only directed scenarios can show how the table evolves. These cover the history threshold and address aliasing, both counter clamps, clearing on a miss, the lowered resource-aware limits, the read-before-write order on a same-cycle collision, and the discarded commits while the table is being cleared.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int ENT_W = 8;

  localparam logic [1:0] CM_ONES = 2'd0;
  localparam logic [1:0] CM_SAT  = 2'd1;
  localparam logic [1:0] CM_RST  = 2'd2;

  localparam logic [1:0] TM_FIXED = 2'd0;
  localparam logic [1:0] TM_RES   = 2'd1;
  localparam logic [1:0] TM_CAT   = 2'd2;

  // score of an entry on a common signed scale
  function automatic logic signed [ENT_W-1:0] ent_score(logic [1:0] m, logic [ENT_W-1:0] e);
    logic signed [ENT_W-1:0] s;
    s = '0;
    case (m)
      CM_SAT:  s = {{(ENT_W-4){e[3]}}, e[3:0]};
      CM_RST:  s = {{(ENT_W-4){1'b0}}, e[3:0]};
      default: for (int i = 0; i < ENT_W; i++) s = s + {{(ENT_W-1){1'b0}}, e[i]};
    endcase
    return s;
  endfunction

  function automatic logic signed [ENT_W-1:0] ent_base(logic [1:0] m);
    case (m)
      CM_SAT:  return 8'sd4;
      CM_RST:  return 8'sd11;
      default: return 8'sd6;
    endcase
  endfunction

  function automatic logic [ENT_W-1:0] ent_next(logic [1:0] m, logic [ENT_W-1:0] e, logic ok);
    logic [ENT_W-1:0] n;
    case (m)
      CM_SAT: begin
        if (ok) n = (e[3:0] == 4'b0111) ? {4'b0, e[3:0]} : {4'b0, e[3:0] + 4'd1};
        else    n = (e[3:0] == 4'b1000) ? {4'b0, e[3:0]} : {4'b0, e[3:0] - 4'd1};
      end
      CM_RST: begin
        if (ok) n = (e[3:0] == 4'hF) ? {4'b0, e[3:0]} : {4'b0, e[3:0] + 4'd1};
        else    n = '0;
      end
      default: n = {e[ENT_W-2:0], ok};
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cfc_table.sv
module cfc_table #(
  parameter int IDX_W = 12,
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [ENT_W-1:0] rd_a_q,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [ENT_W-1:0] rd_b_q,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  // one write port, two registered read ports; a write landing on the
  // same edge is forwarded so a reader never sees the stale word
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_a_q <= (wr_en && wr_idx == rd_a_idx) ? wr_data : mem[rd_a_idx];
    rd_b_q <= (wr_en && wr_idx == rd_b_idx) ? wr_data : mem[rd_b_idx];
  end
endmodule

// File: rtl/cfc_update.sv
module cfc_update #(
  parameter int IDX_W = 12,
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cnt_mode,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_ok,
  input  logic [ENT_W-1:0] rd_q,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [ENT_W-1:0] wr_data,
  output logic             clearing
);
  import cfc_pkg::*;

  logic             clr_busy;
  logic [IDX_W-1:0] clr_cnt;
  logic             s1_v;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_ok;

  // clear sweep: one entry per cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy <= 1'b1;
      clr_cnt  <= '0;
    end else if (clr_busy) begin
      clr_cnt <= clr_cnt + 1'b1;
      if (&clr_cnt) clr_busy <= 1'b0;
    end
  end

  // read stage of the read-modify-write
  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= up_valid & ~clr_busy;
    s1_idx <= up_idx;
    s1_ok  <= up_ok;
  end

  always_comb begin
    wr_en   = clr_busy | s1_v;
    wr_idx  = clr_busy ? clr_cnt : s1_idx;
    wr_data = clr_busy ? '0 : ent_next(cnt_mode, rd_q, s1_ok);
  end

  assign clearing = clr_busy;
endmodule

// File: rtl/cfc_decide.sv
module cfc_decide #(
  parameter int FREE_MAX = 3,
  parameter int CTX_W    = 2,
  parameter int CAT_W    = 2,
  parameter int ENT_W    = 8
) (
  input  logic [1:0]       cnt_mode,
  input  logic [1:0]       thr_mode,
  input  logic [ENT_W-1:0] ent,
  input  logic [CTX_W-1:0] free,
  input  logic [CAT_W-1:0] cat,
  input  logic             valid,
  output logic             high,
  output logic             fork_req
);
  import cfc_pkg::*;

  localparam logic [CTX_W-1:0] FMAX = CTX_W'(FREE_MAX);

  logic signed [ENT_W-1:0] score, lim;
  logic [CTX_W-1:0]        deficit;
  logic                    tbl_high, cat_go, hi;

  always_comb begin
    score   = ent_score(cnt_mode, ent);
    deficit = FMAX - free;
    lim     = ent_base(cnt_mode);
    if (thr_mode == TM_RES) lim = lim - ENT_W'(deficit);
    tbl_high = score > lim;
    cat_go   = ENT_W'(cat) < ENT_W'(free);
    hi       = (thr_mode == TM_CAT) ? ~cat_go : tbl_high;
    high     = valid & hi;
    fork_req = valid & ~hi & (free != '0);
  end
endmodule

// File: rtl/conf_fork_ctrl.sv
module conf_fork_ctrl #(
  parameter int IDX_W    = 12,
  parameter int PC_W     = IDX_W + 2,
  parameter int FREE_MAX = 3,
  parameter int CTX_W    = $clog2(FREE_MAX + 1),
  parameter int CAT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cnt_mode_i,
  input  logic [1:0]       thr_mode_i,
  input  logic [CTX_W-1:0] free_ctx_i,
  input  logic             lk_valid_i,
  input  logic [PC_W-1:2]  lk_pc_i,
  input  logic [CAT_W-1:0] lk_cat_i,
  input  logic             up_valid_i,
  input  logic [PC_W-1:2]  up_pc_i,
  input  logic             up_correct_i,
  output logic             res_valid_o,
  output logic             res_high_o,
  output logic             res_fork_o
);
  import cfc_pkg::*;

  function automatic logic [IDX_W-1:0] pc2idx(logic [1:0] m, logic [PC_W-1:2] pc);
    if (m == CM_SAT || m == CM_RST) return pc[2 +: IDX_W];
    return {1'b0, pc[2 +: IDX_W-1]};
  endfunction

  logic [IDX_W-1:0] lk_idx, up_idx, wr_idx;
  logic [ENT_W-1:0] a_q, b_q, wr_data, ent;
  logic             wr_en, clr_busy;

  logic             v_q, zero_q;
  logic [CTX_W-1:0] free_q;
  logic [CAT_W-1:0] cat_q;
  logic [1:0]       thr_q;

  assign lk_idx = pc2idx(cnt_mode_i, lk_pc_i);
  assign up_idx = pc2idx(cnt_mode_i, up_pc_i);

  cfc_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tab (
    .clk(clk), .rd_a_idx(lk_idx), .rd_a_q(a_q),
    .rd_b_idx(up_idx), .rd_b_q(b_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfc_update #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_upd (
    .clk(clk), .rst(rst), .cnt_mode(cnt_mode_i),
    .up_valid(up_valid_i), .up_idx(up_idx), .up_ok(up_correct_i),
    .rd_q(b_q), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .clearing(clr_busy)
  );

  // lookup side-band travels beside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      zero_q <= 1'b1;
      free_q <= '0;
      cat_q  <= '0;
      thr_q  <= TM_FIXED;
    end else begin
      v_q    <= lk_valid_i;
      zero_q <= clr_busy;
      free_q <= free_ctx_i;
      cat_q  <= lk_cat_i;
      thr_q  <= thr_mode_i;
    end
  end

  assign ent = zero_q ? '0 : a_q;

  cfc_decide #(.FREE_MAX(FREE_MAX), .CTX_W(CTX_W), .CAT_W(CAT_W), .ENT_W(ENT_W)) u_dec (
    .cnt_mode(cnt_mode_i), .thr_mode(thr_q), .ent(ent),
    .free(free_q), .cat(cat_q), .valid(v_q),
    .high(res_high_o), .fork_req(res_fork_o)
  );

  assign res_valid_o = v_q;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int CTX_W = 2,
  parameter int CAT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       thr_mode_i,
  input logic [CTX_W-1:0] free_ctx_i,
  input logic             lk_valid_i,
  input logic [CAT_W-1:0] lk_cat_i,
  input logic             res_valid_o,
  input logic             res_high_o,
  input logic             res_fork_o
);
  p_lat_valid_r1: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> res_valid_o);
  p_lat_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !res_valid_o);
  p_high_valid_r1: assert property (@(posedge clk) disable iff (rst)
    res_high_o |-> res_valid_o);
  p_no_ctx_r6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_i && free_ctx_i == '0) |=> !res_fork_o);
  p_fork_excl_r6: assert property (@(posedge clk) disable iff (rst)
    res_fork_o |-> (res_valid_o && !res_high_o));
  p_cat_go_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_i && thr_mode_i == 2'd2 && 8'(lk_cat_i) < 8'(free_ctx_i)) |=> res_fork_o);
  p_cat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (lk_valid_i && thr_mode_i == 2'd2 && !(8'(lk_cat_i) < 8'(free_ctx_i))) |=> !res_fork_o);
endmodule

bind conf_fork_ctrl cfc_checker #(.CTX_W(CTX_W), .CAT_W(CAT_W)) u_chk (
  .clk(clk), .rst(rst), .thr_mode_i(thr_mode_i), .free_ctx_i(free_ctx_i),
  .lk_valid_i(lk_valid_i), .lk_cat_i(lk_cat_i),
  .res_valid_o(res_valid_o), .res_high_o(res_high_o), .res_fork_o(res_fork_o)
);

// File: tb/tb_conf_fork_ctrl.sv
`timescale 1ns/1ps
module tb_conf_fork_ctrl;
  localparam int IDX_W = 12;
  localparam int PC_W  = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cnt_mode_i = 2'd0, thr_mode_i = 2'd0;
  logic [1:0]       free_ctx_i = 2'd0;
  logic             lk_valid_i = 1'b0, up_valid_i = 1'b0, up_correct_i = 1'b0;
  logic [PC_W-1:2]  lk_pc_i = '0, up_pc_i = '0;
  logic [1:0]       lk_cat_i = 2'd0;
  logic             res_valid_o, res_high_o, res_fork_o;

  conf_fork_ctrl #(.IDX_W(IDX_W), .PC_W(PC_W)) dut (.*);

  always #10 clk = ~clk;

  typedef struct { logic h; logic f; int cyc; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, nchk = 0, nerr = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: compares each result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && res_valid_o) begin
      if (q.size() == 0) chk(0, "R1 result without lookup", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res_high_o == e.h && res_fork_o == e.f && cyc == e.cyc, e.tag,
            {res_high_o, res_fork_o, 16'(cyc)}, {e.h, e.f, 16'(e.cyc)});
      end
    end
  end

  task automatic lke(int pc, int cat, int free, int thr, bit eh, bit ef, string tag);
    exp_t e;
    @(negedge clk);
    up_valid_i = 0; lk_valid_i = 1;
    lk_pc_i = (PC_W-2)'(pc >> 2); lk_cat_i = 2'(cat);
    free_ctx_i = 2'(free); thr_mode_i = 2'(thr);
    e.h = eh; e.f = ef; e.cyc = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic upd(int pc, bit ok, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid_i = 0; up_valid_i = 1;
      up_pc_i = (PC_W-2)'(pc >> 2); up_correct_i = ok;
    end
  endtask

  task automatic both(int pc, bit ok, bit eh, bit ef, string tag);
    lke(pc, 0, 2, 0, eh, ef, tag);
    up_valid_i = 1; up_pc_i = (PC_W-2)'(pc >> 2); up_correct_i = ok;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid_i = 0; up_valid_i = 0;
    end
  endtask

  task automatic do_reset(int mode);
    @(negedge clk);
    rst = 1; lk_valid_i = 0; up_valid_i = 0; cnt_mode_i = 2'(mode);
    idle(3);
    chk(res_valid_o == 0 && res_high_o == 0 && res_fork_o == 0, "R2 outputs low in reset",
        {res_valid_o, res_high_o, res_fork_o}, 0);
    rst = 0;
  endtask

  localparam int A = 32'h0040, AA = 32'h2040, B = 32'h0080;
  localparam int C = 32'h0100, D = 32'h0200;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    // ones-count mode
    do_reset(0);
    lke(A, 0, 3, 0, 0, 1, "R10 lookup during clear reads zero");
    upd(B, 1, 8);
    idle(4100);
    lke(B, 0, 3, 0, 0, 1, "R10 commits in clear window dropped");
    lke(A, 0, 2, 0, 0, 1, "R2 zero entry low confidence forks");
    upd(A, 1, 8);
    lke(A, 0, 2, 0, 1, 0, "R3 eight correct is high");
    lke(AA, 0, 2, 0, 1, 0, "R3 bit13 alias shares entry");
    upd(A, 0, 1);
    lke(A, 0, 2, 0, 1, 0, "R3 seven ones still high");
    upd(A, 0, 1);
    lke(A, 0, 2, 0, 0, 1, "R3 two misses fork");
    lke(A, 0, 0, 0, 0, 0, "R6 no spare context no fork");
    lke(A, 0, 2, 1, 1, 0, "R7 spare2 limit5");
    lke(A, 0, 1, 1, 1, 0, "R7 spare1 limit4");
    lke(A, 0, 3, 1, 0, 1, "R7 spare3 full limit");
    lke(A, 1, 2, 2, 0, 1, "R8 cat1 spare2 forks");
    lke(A, 2, 2, 2, 1, 0, "R8 cat2 spare2 holds");
    lke(A, 0, 1, 2, 0, 1, "R8 cat0 spare1 forks");
    lke(A, 0, 0, 2, 1, 0, "R8 cat0 spare0 holds");
    upd(A, 1, 8);
    both(A, 0, 1, 0, "R9 collision sees eight ones");
    both(A, 0, 1, 0, "R9 collision sees seven ones");
    lke(A, 0, 2, 0, 0, 1, "R9 commit visible next cycle");
    idle(4);

    // saturating mode
    do_reset(1);
    idle(4100);
    upd(C, 1, 4);
    lke(C, 0, 2, 0, 0, 1, "R4 four is not above limit");
    upd(C, 1, 1);
    lke(C, 0, 2, 0, 1, 0, "R4 five is high");
    lke(C | 32'h2000, 0, 2, 0, 0, 1, "R4 bit13 selects own entry");
    upd(C, 1, 6);
    upd(C, 0, 3);
    lke(C, 0, 2, 0, 0, 1, "R4 clamp at plus7");
    upd(C, 0, 20);
    upd(C, 1, 13);
    lke(C, 0, 2, 0, 1, 0, "R4 clamp at minus8");
    upd(C, 0, 2);
    lke(C, 0, 3, 0, 0, 1, "R4 three is low");
    lke(C, 0, 1, 1, 1, 0, "R7 saturating spare1 limit2");
    idle(4);

    // resetting mode
    do_reset(2);
    idle(4100);
    upd(D, 1, 11);
    lke(D, 0, 2, 0, 0, 1, "R5 eleven is low");
    upd(D, 1, 1);
    lke(D, 0, 2, 0, 1, 0, "R5 twelve is high");
    upd(D, 0, 1);
    lke(D, 0, 2, 0, 0, 1, "R5 miss clears");
    upd(D, 1, 20);
    lke(D, 0, 2, 0, 1, 0, "R5 holds at 15");
    upd(D, 0, 1);
    lke(D, 0, 1, 1, 0, 1, "R7 resetting spare1 zero forks");
    idle(5);
    chk(q.size() == 0, "R1 every lookup answered", q.size(), 0);
    finish_run();
  end
endmodule